// File: doc/BRIEF.md
# SMBus Over-Temperature Monitor Target

This block is the bus-facing half of an on-package temperature monitor. A digital temperature code arrives on a parallel input. A controller on a two-wire SMBus segment reads that code, programs an upper threshold, and inspects a status byte. The block runs entirely in the system clock domain. It oversamples the SCL and SDA wires, finds START and STOP conditions and clock edges, and drives SDA only by pulling it low.

When the registered temperature goes strictly above the threshold, a sticky alert flag is set and the active-low alert pin is pulled. The controller can find the source of the alert in either of two ways. It can read the status byte, which clears the flag once the temperature has fallen back. It can also issue a read to the shared alert-response address, which this target answers with its own address. That answer releases the pin until the flag clears and sets again.

The target's 7-bit address is built from a 2-bit family strap and a 3-bit low-address strap. This allows several monitors to share one segment.

Top module: `thermal_smb_target`

## Requirements
- R1: The bus address is {F, addr_lo_i}, where F is 4'b0011 for addr_fam_i 0 or 3, 4'b1001 for 1 and 4'b0101 for 2. The target acknowledges only this address, plus the alert-response read of R8. Any other address byte gets no acknowledge, and the target leaves SDA released until the next START.
- R2: A write-byte transaction has the form address+W, then a command byte (the register pointer), then one data byte. The data byte is acknowledged and stored only when the pointer is 1 (high limit). Data sent to any other pointer, and any third byte, is not acknowledged and changes nothing.
- R3: A read-byte transaction has the form address+W, command, repeated START, address+R, and the target then returns one byte. Pointer 0 returns the temperature, which is temp_i registered once. Pointer 1 returns the high limit. Pointer 2 returns status: bit 0 is the latched alert, bit 1 is the live "temperature above limit" flag, and the other bits are 0. Any other pointer returns 0.
- R4: A send-byte transaction (address+W, one byte) sets the pointer. A receive-byte transaction (address+R) returns the register at the current pointer. The pointer persists across transactions.
- R5: The alert flag sets when the registered temperature is strictly greater than the limit, as an unsigned comparison. The alert pin reflects this two clocks after temp_i changes. Equality does not set the flag.
- R6: Once set, the alert flag stays set until a status read (pointer 2) happens while the temperature is not above the limit. That read returns the value from before the clear.
- R7: alert_no is low exactly while the alert flag is set and has not been claimed by an alert-response read.
- R8: A read of address 7'b0001100 is acknowledged only while the alert is pending (set and not yet claimed). The target returns {own address, 1'b0} and alert_no goes high. A later clear of the flag re-arms the pin. With no alert pending, that address is not acknowledged.
- R9: After reset, SDA is released, alert_no is high, the pointer is 0 and the high limit equals LIMIT_RST (8'h50 by default).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, oversamples the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SMBus clock wire level |
| sda_i | input | 1 | SMBus data wire level |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| addr_fam_i | input | 2 | Address family strap |
| addr_lo_i | input | 3 | Low three address bits strap |
| temp_i | input | 8 | Digital temperature code |
| alert_no | output | 1 | Active-low alert, open-drain style |

## Verification
A corrupted alert flag or claim bit shows up on alert_no. Because the bench's model predicts that pin on every clock outside transactions, the fault is seen within one clock of the bus going idle. A wrong pointer, limit or bit-level state shows up in the very next transaction, as a missing acknowledge or a wrong returned byte. Status reads are used to expose the flag and the live comparison directly. Alert-response reads expose the claim state and the address straps.

// File: rtl/thermal_smb_pkg.sv
package thermal_smb_pkg;
  localparam int BYTE_W = 8;
  localparam logic [6:0] ARA_ADDR = 7'b0001100;
  localparam logic [BYTE_W-1:0] PTR_TEMP  = 8'd0;
  localparam logic [BYTE_W-1:0] PTR_LIMIT = 8'd1;
  localparam logic [BYTE_W-1:0] PTR_STAT  = 8'd2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ACK_A, ST_RX, ST_ACK_D, ST_TX, ST_TACK, ST_WAIT
  } link_st_e;

  function automatic logic [6:0] own_addr(logic [1:0] fam, logic [2:0] lo);
    logic [3:0] hi;
    case (fam)
      2'd1:    hi = 4'b1001;
      2'd2:    hi = 4'b0101;
      default: hi = 4'b0011;
    endcase
    return {hi, lo};
  endfunction
endpackage

// File: rtl/smb_edge.sv
module smb_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] scl_sh, sda_sh;
  logic scl_d, sda_d, scl_s, sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[MSB-1:0], scl_i};
      sda_sh <= {sda_sh[MSB-1:0], sda_i};
      scl_d  <= scl_sh[MSB];
      sda_d  <= sda_sh[MSB];
    end
  end

  assign scl_s      = scl_sh[MSB];
  assign sda_s      = sda_sh[MSB];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  assign start_o    = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/therm_regs.sv
module therm_regs
  import thermal_smb_pkg::*;
#(
  parameter logic [7:0] LIMIT_RST = 8'h50
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] temp_i,
  input  logic [BYTE_W-1:0] ptr_i,
  input  logic              wr_en_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              rd_stb_i,
  input  logic              ara_ack_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              alert_pend_o,
  output logic              alert_no
);
  logic [BYTE_W-1:0] temp_q, limit_q;
  logic lat_q, mask_q, over;

  assign over = temp_q > limit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      temp_q  <= '0;
      limit_q <= LIMIT_RST;
      lat_q   <= 1'b0;
      mask_q  <= 1'b0;
    end else begin
      temp_q <= temp_i;
      if (wr_en_i) limit_q <= wr_data_i;
      // set wins over the read-to-clear
      if (over) lat_q <= 1'b1;
      else if (rd_stb_i && ptr_i == PTR_STAT) lat_q <= 1'b0;
      if (ara_ack_i) mask_q <= 1'b1;
      else if (!lat_q) mask_q <= 1'b0;
    end
  end

  always_comb begin
    case (ptr_i)
      PTR_TEMP:  rd_data_o = temp_q;
      PTR_LIMIT: rd_data_o = limit_q;
      PTR_STAT:  rd_data_o = {6'b0, over, lat_q};
      default:   rd_data_o = '0;
    endcase
  end

  assign alert_pend_o = lat_q & ~mask_q;
  assign alert_no     = ~alert_pend_o;

  assert_latch_sets_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    over |=> lat_q);
  assert_clear_by_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lat_q) |-> $past(rd_stb_i && ptr_i == PTR_STAT));
  assert_claim_by_ara_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mask_q) |-> $past(ara_ack_i));
endmodule

// File: rtl/smb_link.sv
module smb_link
  import thermal_smb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [6:0]        own_addr_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  input  logic              alert_pend_i,
  output logic [BYTE_W-1:0] ptr_o,
  output logic              wr_en_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              rd_stb_o,
  output logic              ara_ack_o,
  output logic              sda_pull_o
);
  link_st_e st_q;
  logic [2:0] cnt_q;
  logic [1:0] idx_q;
  logic [BYTE_W-1:0] sr_q, tx_q, tx_byte;
  logic got_q, rd_mode_q, ara_mode_q, more_q;

  assign tx_byte = ara_mode_q ? {own_addr_i, 1'b0} : rd_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; cnt_q <= '0; idx_q <= '0; sr_q <= '0; tx_q <= '0;
      got_q <= 1'b0; rd_mode_q <= 1'b0; ara_mode_q <= 1'b0; more_q <= 1'b0;
      ptr_o <= PTR_TEMP; wr_en_o <= 1'b0; wr_data_o <= '0;
      rd_stb_o <= 1'b0; ara_ack_o <= 1'b0; sda_pull_o <= 1'b0;
    end else begin
      wr_en_o <= 1'b0; rd_stb_o <= 1'b0; ara_ack_o <= 1'b0;
      if (stop_i) begin
        st_q <= ST_IDLE; sda_pull_o <= 1'b0;
      end else if (start_i) begin
        st_q <= ST_ADDR; cnt_q <= '0; got_q <= 1'b0; sda_pull_o <= 1'b0;
      end else begin
        case (st_q)
          ST_ADDR, ST_RX: begin
            if (scl_rise_i) begin
              sr_q <= {sr_q[BYTE_W-2:0], sda_i};
              if (cnt_q == 3'd7) got_q <= 1'b1;
              else cnt_q <= cnt_q + 3'd1;
            end else if (scl_fall_i && got_q) begin
              got_q <= 1'b0; cnt_q <= '0;
              if (st_q == ST_ADDR) begin
                if (sr_q[7:1] == own_addr_i) begin
                  sda_pull_o <= 1'b1; st_q <= ST_ACK_A;
                  rd_mode_q <= sr_q[0]; ara_mode_q <= 1'b0; idx_q <= '0;
                end else if (sr_q[7:1] == ARA_ADDR && sr_q[0] && alert_pend_i) begin
                  sda_pull_o <= 1'b1; st_q <= ST_ACK_A;
                  rd_mode_q <= 1'b1; ara_mode_q <= 1'b1; ara_ack_o <= 1'b1;
                end else st_q <= ST_WAIT;
              end else if (idx_q == 2'd0) begin
                ptr_o <= sr_q; sda_pull_o <= 1'b1; st_q <= ST_ACK_D; idx_q <= 2'd1;
              end else if (idx_q == 2'd1 && ptr_o == PTR_LIMIT) begin
                wr_en_o <= 1'b1; wr_data_o <= sr_q;
                sda_pull_o <= 1'b1; st_q <= ST_ACK_D; idx_q <= 2'd2;
              end else st_q <= ST_WAIT;
            end
          end
          ST_ACK_A, ST_TACK: begin
            if (st_q == ST_TACK && scl_rise_i) more_q <= ~sda_i;
            else if (scl_fall_i) begin
              if ((st_q == ST_ACK_A && rd_mode_q) || (st_q == ST_TACK && more_q)) begin
                // first data bit goes out on the fall ending the ack clock
                st_q <= ST_TX; cnt_q <= '0;
                sda_pull_o <= ~tx_byte[7];
                tx_q <= {tx_byte[6:0], 1'b0};
                rd_stb_o <= ~ara_mode_q;
              end else if (st_q == ST_ACK_A) begin
                sda_pull_o <= 1'b0; st_q <= ST_RX;
              end else st_q <= ST_WAIT;
            end
          end
          ST_ACK_D: if (scl_fall_i) begin sda_pull_o <= 1'b0; st_q <= ST_RX; end
          ST_TX: if (scl_fall_i) begin
            if (cnt_q == 3'd7) begin
              sda_pull_o <= 1'b0; st_q <= ST_TACK; more_q <= 1'b0;
            end else begin
              sda_pull_o <= ~tx_q[7]; tx_q <= {tx_q[6:0], 1'b0}; cnt_q <= cnt_q + 3'd1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_addr_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ADDR) |-> !sda_pull_o);
  assert_write_limit_only_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> ptr_o == PTR_LIMIT);
  assert_ara_pending_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ara_ack_o |-> $past(alert_pend_i));
endmodule

// File: rtl/thermal_smb_target.sv
module thermal_smb_target
  import thermal_smb_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] LIMIT_RST   = 8'h50
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  input  logic [1:0] addr_fam_i,
  input  logic [2:0] addr_lo_i,
  input  logic [7:0] temp_i,
  output logic       alert_no
);
  logic sda_s, scl_rise, scl_fall, start, stop;
  logic wr_en, rd_stb, ara_ack, alert_pend;
  logic [BYTE_W-1:0] ptr, wr_data, rd_data;

  smb_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i, .rst_ni, .scl_i, .sda_i, .sda_o(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall), .start_o(start), .stop_o(stop)
  );

  smb_link u_link (
    .clk_i, .rst_ni, .sda_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start), .stop_i(stop), .own_addr_i(own_addr(addr_fam_i, addr_lo_i)),
    .rd_data_i(rd_data), .alert_pend_i(alert_pend), .ptr_o(ptr), .wr_en_o(wr_en),
    .wr_data_o(wr_data), .rd_stb_o(rd_stb), .ara_ack_o(ara_ack), .sda_pull_o
  );

  therm_regs #(.LIMIT_RST(LIMIT_RST)) u_regs (
    .clk_i, .rst_ni, .temp_i, .ptr_i(ptr), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_stb_i(rd_stb), .ara_ack_i(ara_ack), .rd_data_o(rd_data),
    .alert_pend_o(alert_pend), .alert_no
  );
endmodule

// File: tb/thermal_smb_target_tb.sv
`timescale 1ns/1ps
module thermal_smb_target_tb;
  localparam int H = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_drv = 1'b1, sda_drv = 1'b1;
  logic [1:0] fam = 2'd0;
  logic [2:0] lo = 3'd3;
  logic [7:0] temp_drv = 8'h20;
  logic sda_pull, alert_n, sda_line;
  int n_cmp = 0, n_bad = 0;
  bit cmp_en = 1'b0, done = 1'b0;

  // behavioural reference state
  int m_tq = 0, m_lim = 'h50;
  bit m_lat = 0, m_mask = 0;

  always #2.5 clk = ~clk;
  assign sda_line = sda_drv & ~sda_pull;

  thermal_smb_target u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_drv), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .addr_fam_i(fam), .addr_lo_i(lo),
    .temp_i(temp_drv), .alert_no(alert_n)
  );

  function automatic logic [6:0] addr_of(logic [1:0] f, logic [2:0] l);
    if (f == 2'd1) return {4'b1001, l};
    if (f == 2'd2) return {4'b0101, l};
    return {4'b0011, l};
  endfunction

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tq = 0; m_lim = 'h50; m_lat = 0; m_mask = 0;
    end else begin
      bit old_lat;
      old_lat = m_lat;
      if (m_tq > m_lim) m_lat = 1;
      if (!old_lat) m_mask = 0;
      m_tq = temp_drv;
    end
  end

  always @(negedge clk)
    if (cmp_en) check("R7 alert pin vs model", alert_n, !(m_lat && !m_mask));

  task automatic hp; repeat (H) @(negedge clk); endtask

  task automatic bus_start;
    sda_drv = 1; hp; scl_drv = 1; hp; sda_drv = 0; hp; scl_drv = 0; hp;
  endtask
  task automatic bus_stop;
    sda_drv = 0; hp; scl_drv = 1; hp; sda_drv = 1; hp;
  endtask
  task automatic put_bit(input logic b);
    sda_drv = b; hp; scl_drv = 1; hp; scl_drv = 0;
  endtask
  task automatic get_bit(output logic b);
    sda_drv = 1; hp; scl_drv = 1; repeat (H/2) @(negedge clk);
    b = sda_line; repeat (H - H/2) @(negedge clk); scl_drv = 0;
  endtask
  task automatic wb(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b); ack = ~b;
  endtask
  task automatic rb(output logic [7:0] d, input logic ack);
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
    put_bit(~ack);
  endtask

  task automatic begin_txn; cmp_en = 0; bus_start; endtask
  task automatic end_txn; bus_stop; repeat (6) @(negedge clk); endtask

  task automatic status_effect(input int ptr);
    if (ptr == 2 && !(m_tq > m_lim)) m_lat = 0;
  endtask
  function automatic int model_reg(input int ptr);
    case (ptr)
      0: return m_tq;
      1: return m_lim;
      2: return ((m_tq > m_lim) ? 2 : 0) | int'(m_lat);
      default: return 0;
    endcase
  endfunction

  task automatic write_reg(input int ptr, input int data, input logic exp_ack, input string tag);
    logic a; logic [6:0] ad = addr_of(fam, lo);
    begin_txn;
    wb({ad, 1'b0}, a); check({tag, " addr ack"}, a, 1);
    wb(ptr[7:0], a);   check({tag, " cmd ack"}, a, 1);
    wb(data[7:0], a);  check({tag, " data ack"}, a, exp_ack);
    end_txn;
    if (exp_ack) m_lim = data;
    cmp_en = 1;
  endtask

  task automatic read_reg(input int ptr, input string tag);
    logic a; logic [7:0] d; logic [6:0] ad = addr_of(fam, lo); int e;
    begin_txn;
    wb({ad, 1'b0}, a); check({tag, " addr ack"}, a, 1);
    wb(ptr[7:0], a);   check({tag, " cmd ack"}, a, 1);
    bus_start;
    wb({ad, 1'b1}, a); check({tag, " raddr ack"}, a, 1);
    e = model_reg(ptr);
    rb(d, 1'b0);       check({tag, " data"}, d, e);
    end_txn;
    status_effect(ptr);
    cmp_en = 1;
  endtask

  task automatic send_ptr(input int ptr);
    logic a; logic [6:0] ad = addr_of(fam, lo);
    begin_txn;
    wb({ad, 1'b0}, a); check("R4 send addr ack", a, 1);
    wb(ptr[7:0], a);   check("R4 send ptr ack", a, 1);
    end_txn; cmp_en = 1;
  endtask

  task automatic recv(input int ptr);
    logic a; logic [7:0] d; logic [6:0] ad = addr_of(fam, lo); int e;
    begin_txn;
    wb({ad, 1'b1}, a); check("R4 recv addr ack", a, 1);
    e = model_reg(ptr);
    rb(d, 1'b0);       check("R4 recv data", d, e);
    end_txn;
    status_effect(ptr);
    cmp_en = 1;
  endtask

  task automatic probe(input logic [6:0] ad, input logic rw, input logic exp, input string tag);
    logic a;
    begin_txn;
    wb({ad, rw}, a); check(tag, a, exp);
    if (a && rw) begin logic [7:0] d; rb(d, 1'b0); end
    end_txn; cmp_en = 1;
  endtask

  task automatic ara(input logic exp_ack);
    logic a; logic [7:0] d;
    begin_txn;
    wb({7'b0001100, 1'b1}, a); check("R8 ARA ack", a, exp_ack);
    if (a) begin
      rb(d, 1'b0); check("R8 ARA returned address", d, {addr_of(fam, lo), 1'b0});
    end
    end_txn;
    if (exp_ack) m_mask = 1;
    cmp_en = 1;
  endtask

  task automatic set_temp(input int t);
    temp_drv = t[7:0]; repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R9 reset sda released", sda_pull, 0);
    check("R9 reset alert high", alert_n, 1);
    cmp_en = 1;
    repeat (4) @(negedge clk);
    recv(0);                      // R9 pointer resets to temperature
    read_reg(1, "R9 limit reset");
    read_reg(0, "R3 temp");
    read_reg(2, "R3 status idle");
    read_reg(5, "R3 unknown ptr");
    write_reg(1, 'h30, 1, "R2 limit write");
    read_reg(1, "R2 limit readback");
    write_reg(0, 'h77, 0, "R2 temp write refused");
    read_reg(0, "R2 temp unchanged");
    write_reg(2, 'h55, 0, "R2 status write refused");
    read_reg(1, "R2 limit unchanged");
    probe(7'h1A, 0, 0, "R1 wrong low bits nack");
    probe({4'b1001, 3'd3}, 0, 0, "R1 wrong family nack");
    send_ptr(1);
    recv(1);
    recv(1);                      // R4 pointer persists
    set_temp('h30);
    check("R5 equal no alert", alert_n, 1);
    read_reg(2, "R5 status at equality");
    ara(0);                       // R8 nothing pending
    set_temp('h31);
    check("R5 above sets alert", alert_n, 0);
    read_reg(2, "R6 status while hot");
    check("R6 still alerting", alert_n, 0);
    set_temp('h10);
    check("R6 latched after cooling", alert_n, 0);
    read_reg(2, "R6 status clears");
    check("R6 alert released after read", alert_n, 1);
    read_reg(2, "R6 status cleared");
    set_temp('h40);
    ara(1);
    check("R8 alert released by ARA", alert_n, 1);
    read_reg(2, "R8 latch survives ARA");
    ara(0);                       // R8 already claimed
    set_temp('h10);
    read_reg(2, "R8 clear after claim");
    set_temp('h40);
    check("R8 re-armed alert", alert_n, 0);
    set_temp('h10);
    read_reg(2, "R6 final clear");
    fam = 2'd1; lo = 3'd5; repeat (4) @(negedge clk);
    read_reg(1, "R1 family 1001");
    probe(7'h1B, 1, 0, "R1 old address nack");
    fam = 2'd2; lo = 3'd0; repeat (4) @(negedge clk);
    read_reg(0, "R1 family 0101");
    fam = 2'd3; lo = 3'd7; repeat (4) @(negedge clk);
    read_reg(1, "R1 family code 3");
    set_temp('h90);
    ara(1);                       // R8 reports strap address
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule